// File: doc/BRIEF.md
# Stereo Digital Volume with Peak Meter

This block sits in front of a two-channel DAC modulator. It accepts left and right signed 24-bit PCM samples qualified by a sample strobe and scales each channel by its own logarithmic attenuation setting. It returns the attenuated pair one clock later, together with an output strobe. A setting of 0 passes samples through unchanged, and each further increment takes roughly another 0.375 dB off the gain. There are 256 settings per channel.

For each channel the block keeps the largest output magnitude seen since that channel's meter was last read. Reading a meter returns its value and clears it. A zero-detect flag per channel is meant for an external pin. It rises after a long unbroken run of zero input samples and falls on the first non-zero one.

A small register port lets a host write the two attenuation settings, read them back, and read the two meters. Both channels stay silent after reset until the host has written their setting, so the DAC produces no noise while the system is being configured.

Top module: `stereo_vol_meter`

## Requirements
- R1: After reset every output is zero. Each channel produces zero samples until its own attenuation setting has been written at least once, even if the written value is 0. A write to one channel does not unmute the other.
- R2: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high. The output samples change only in those cycles and hold their value otherwise.
- R3: With setting k, an output equals the input times 10^(-0.375·k/20), rounded to nearest. The result may be off by at most 1 plus |x|·2^-19 LSB. Setting 0 is an exact pass-through, including -2^23 and 2^23-1.
- R4: The channels are independent. Address 0 sets only the left channel's attenuation and address 1 sets only the right channel's.
- R5: A setting written in an earlier cycle applies to the very next strobed sample.
- R6: Each meter holds the largest magnitude of that channel's output since it was last cleared. The output value -2^23 counts as magnitude 2^23-1.
- R7: A read with `reg_rd` high puts the selected value on `reg_rdata` in the next cycle. Reading a meter clears it to zero, so an immediate second read returns 0.
- R8: If a meter read and a strobed sample fall in the same cycle, the read returns the value from before that sample. The meter then holds that sample's magnitude instead of zero.
- R9: A channel's zero flag rises after its 1024th consecutive zero input sample. It is still low after the 1023rd, and it falls after the first non-zero sample. The channels do not affect each other.
- R10: Register map on `reg_addr`: 0 is the left setting and 1 is the right setting, both write and read-back, zero-extended on read. 2 is the left meter and 3 is the right meter, both read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample strobe |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 24 | Attenuated left sample |
| out_right | output | 24 | Attenuated right sample |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data (attenuation setting) |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 24 | Read data, valid the cycle after `reg_rd` |
| zero_left | output | 1 | Left zero-run flag |
| zero_right | output | 1 | Right zero-run flag |

## Verification
The scaling path is driven with a table of setting pairs that mixes small, middle and extreme settings. The samples include both full-scale extremes, tiny values of ±1 and mid-range values. This separates a wrong step size, a wrong rounding direction and a swapped channel, because each channel uses a different setting and sign. Setting 0 with -2^23 and 2^23-1 checks exact pass-through and the saturation edge. A meter fed with mixed-sign values shows whether it ranks magnitude or signed value. Zero runs of 1023 and 1024 samples, with the other channel kept non-zero, pin down the flag threshold and the independence of the channels.

// File: rtl/svm_pkg.sv
package svm_pkg;

  localparam int SVM_SAMPLE_W  = 24;
  localparam int SVM_VOL_W     = 8;
  localparam int SVM_NUM_CH    = 2;
  localparam int SVM_ZERO_RUN  = 1024;
  localparam int SVM_GAIN_FRAC = 23;
  // round(2^23 * 10^(-0.375/20)): one attenuation step in Q1.23
  localparam longint SVM_GAIN_STEP = 64'd8034149;

  // Linear gain of a setting, built by repeated multiplication by one step.
  function automatic longint gain_at(input int k, input int frac, input longint step);
    longint g;
    g = longint'(1) << frac;
    for (int i = 0; i < k; i++) begin
      g = (g * step + (longint'(1) << (frac - 1))) >> frac;
    end
    return g;
  endfunction

endpackage

// File: rtl/svm_gain_rom.sv
module svm_gain_rom #(
  parameter int     VOL_W     = 8,
  parameter int     GAIN_FRAC = 23,
  parameter longint GAIN_STEP = 64'd8034149,
  localparam int    GAIN_W    = GAIN_FRAC + 1,
  localparam int    NUM_STEPS = 1 << VOL_W
) (
  input  logic [VOL_W-1:0]  setting,
  input  logic              live,
  output logic [GAIN_W-1:0] gain
);

  logic [GAIN_W-1:0] tab [NUM_STEPS];

  for (genvar k = 0; k < NUM_STEPS; k++) begin : g_entry
    localparam longint ENTRY = svm_pkg::gain_at(k, GAIN_FRAC, GAIN_STEP);
    assign tab[k] = ENTRY[GAIN_W-1:0];
  end

  // Muted channels get a zero multiplier.
  always_comb begin
    if (live) gain = tab[setting];
    else      gain = '0;
  end

endmodule

// File: rtl/svm_scaler.sv
module svm_scaler #(
  parameter int  SAMPLE_W  = 24,
  parameter int  GAIN_FRAC = 23,
  localparam int GAIN_W    = GAIN_FRAC + 1,
  localparam int PROD_W    = SAMPLE_W + GAIN_W + 1,
  localparam int MAG_W     = SAMPLE_W - 1
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic        [GAIN_W-1:0]   gain,
  output logic signed [SAMPLE_W-1:0] scaled,
  output logic        [MAG_W-1:0]    magnitude
);

  localparam logic signed [PROD_W-1:0] HALF   = PROD_W'(1) <<< (GAIN_FRAC - 1);
  localparam logic signed [PROD_W-1:0] POS_LIM = PROD_W'((longint'(1) << (SAMPLE_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] NEG_LIM = -(PROD_W'(1) <<< (SAMPLE_W - 1));
  localparam logic signed [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic signed [PROD_W-1:0] sample_x;
  logic signed [PROD_W-1:0] gain_x;
  logic signed [PROD_W-1:0] product;
  logic signed [PROD_W-1:0] rounded;
  logic signed [SAMPLE_W-1:0] negated;

  always_comb begin
    sample_x = PROD_W'(sample);
    gain_x   = PROD_W'($signed({1'b0, gain}));
    product  = sample_x * gain_x;
    rounded  = (product + HALF) >>> GAIN_FRAC;
    if (rounded > POS_LIM)      scaled = POS_LIM[SAMPLE_W-1:0];
    else if (rounded < NEG_LIM) scaled = NEG_LIM[SAMPLE_W-1:0];
    else                        scaled = rounded[SAMPLE_W-1:0];
  end

  // Magnitude with the most negative code folded onto full scale.
  always_comb begin
    negated = -scaled;
    if (scaled == MOST_NEG)  magnitude = '1;
    else if (scaled[SAMPLE_W-1]) magnitude = negated[MAG_W-1:0];
    else                     magnitude = scaled[MAG_W-1:0];
  end

endmodule

// File: rtl/svm_peak_hold.sv
module svm_peak_hold #(
  parameter int MAG_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic [MAG_W-1:0] magnitude,
  input  logic             rd_clr,
  output logic [MAG_W-1:0] peak
);

  logic [MAG_W-1:0] peak_q;
  logic [MAG_W-1:0] peak_d;
  logic [MAG_W-1:0] floor_v;

  always_comb begin
    floor_v = rd_clr ? '0 : peak_q;
    peak_d  = floor_v;
    if (sample_en && (magnitude > floor_v)) peak_d = magnitude;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   peak_q <= '0;
    else if (sample_en || rd_clr) peak_q <= peak_d;
  end

  assign peak = peak_q;

endmodule

// File: rtl/svm_zero_watch.sv
module svm_zero_watch #(
  parameter int  ZERO_RUN = 1024,
  localparam int CNT_W    = $clog2(ZERO_RUN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic is_zero,
  output logic flag
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ZERO_RUN);

  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_d;

  always_comb begin
    run_d = run_q;
    if (!is_zero)           run_d = '0;
    else if (run_q < LIMIT) run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_q <= '0;
    else if (sample_en) run_q <= run_d;
  end

  assign flag = (run_q == LIMIT);

endmodule

// File: rtl/stereo_vol_meter.sv
module stereo_vol_meter
  import svm_pkg::*;
#(
  parameter int     SAMPLE_W  = SVM_SAMPLE_W,
  parameter int     VOL_W     = SVM_VOL_W,
  parameter int     ZERO_RUN  = SVM_ZERO_RUN,
  parameter int     GAIN_FRAC = SVM_GAIN_FRAC,
  parameter longint GAIN_STEP = SVM_GAIN_STEP,
  localparam int    NUM_CH    = SVM_NUM_CH,
  localparam int    ADDR_W    = $clog2(2 * NUM_CH),
  localparam int    GAIN_W    = GAIN_FRAC + 1,
  localparam int    MAG_W     = SAMPLE_W - 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_left,
  input  logic signed [SAMPLE_W-1:0] in_right,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_left,
  output logic signed [SAMPLE_W-1:0] out_right,
  input  logic        [ADDR_W-1:0]   reg_addr,
  input  logic                       reg_wr,
  input  logic        [VOL_W-1:0]    reg_wdata,
  input  logic                       reg_rd,
  output logic        [SAMPLE_W-1:0] reg_rdata,
  output logic                       zero_left,
  output logic                       zero_right
);

  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic signed [SAMPLE_W-1:0] ch_in   [NUM_CH];
  logic signed [SAMPLE_W-1:0] ch_out  [NUM_CH];
  logic        [VOL_W-1:0]    ch_vol  [NUM_CH];
  logic        [MAG_W-1:0]    ch_peak [NUM_CH];
  logic                       ch_zero [NUM_CH];

  assign ch_in[0] = in_left;
  assign ch_in[1] = in_right;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [VOL_W-1:0]           vol_q, vol_d;
    logic                       live_q, live_d;
    logic                       sel_wr, sel_clr;
    logic [GAIN_W-1:0]          gain;
    logic signed [SAMPLE_W-1:0] scaled;
    logic [MAG_W-1:0]           mag;
    logic signed [SAMPLE_W-1:0] out_q;

    assign sel_wr  = reg_wr && (reg_addr == ADDR_W'(ch));
    assign sel_clr = reg_rd && (reg_addr == ADDR_W'(NUM_CH + ch));

    always_comb begin
      vol_d  = vol_q;
      live_d = live_q;
      if (sel_wr) begin
        vol_d  = reg_wdata;
        live_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_core_n) begin
      if (!rst_core_n) begin
        vol_q  <= '0;
        live_q <= 1'b0;
      end else if (sel_wr) begin
        vol_q  <= vol_d;
        live_q <= live_d;
      end
    end

    svm_gain_rom #(
      .VOL_W    (VOL_W),
      .GAIN_FRAC(GAIN_FRAC),
      .GAIN_STEP(GAIN_STEP)
    ) i_gain (
      .setting(vol_q),
      .live   (live_q),
      .gain   (gain)
    );

    svm_scaler #(
      .SAMPLE_W (SAMPLE_W),
      .GAIN_FRAC(GAIN_FRAC)
    ) i_scale (
      .sample   (ch_in[ch]),
      .gain     (gain),
      .scaled   (scaled),
      .magnitude(mag)
    );

    always_ff @(posedge clk or negedge rst_core_n) begin
      if (!rst_core_n)   out_q <= '0;
      else if (in_valid) out_q <= scaled;
    end

    svm_peak_hold #(
      .MAG_W(MAG_W)
    ) i_peak (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .sample_en(in_valid),
      .magnitude(mag),
      .rd_clr   (sel_clr),
      .peak     (ch_peak[ch])
    );

    svm_zero_watch #(
      .ZERO_RUN(ZERO_RUN)
    ) i_zero (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .sample_en(in_valid),
      .is_zero  (ch_in[ch] == '0),
      .flag     (ch_zero[ch])
    );

    assign ch_out[ch] = out_q;
    assign ch_vol[ch] = vol_q;
  end

  // Output strobe
  logic valid_q;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) valid_q <= 1'b0;
    else             valid_q <= in_valid;
  end

  // Read port: selected value captured on the read strobe
  logic [SAMPLE_W-1:0] rdata_d, rdata_q;

  always_comb begin
    rdata_d = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_addr == ADDR_W'(c))          rdata_d = SAMPLE_W'(ch_vol[c]);
      if (reg_addr == ADDR_W'(NUM_CH + c)) rdata_d = SAMPLE_W'(ch_peak[c]);
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) rdata_q <= '0;
    else if (reg_rd) rdata_q <= rdata_d;
  end

  assign out_valid  = valid_q;
  assign out_left   = ch_out[0];
  assign out_right  = ch_out[1];
  assign reg_rdata  = rdata_q;
  assign zero_left  = ch_zero[0];
  assign zero_right = ch_zero[1];

endmodule

// File: rtl/svm_checker.sv
module svm_checker #(
  parameter int SAMPLE_W = 24
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic signed [SAMPLE_W-1:0] in_left,
  input logic signed [SAMPLE_W-1:0] in_right,
  input logic                       out_valid,
  input logic signed [SAMPLE_W-1:0] out_left,
  input logic signed [SAMPLE_W-1:0] out_right,
  input logic                       zero_left,
  input logic                       zero_right
);

  a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_no_extra_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_left) && $stable(out_right)));

  a_r9_left_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_left != '0) |=> !zero_left);

  a_r9_right_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_right != '0) |=> !zero_right);

  a_r9_left_rise_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_left) |-> ($past(in_valid) && $past(in_left) == '0));

  a_r9_right_rise_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_right) |-> ($past(in_valid) && $past(in_right) == '0));

endmodule

bind stereo_vol_meter svm_checker #(.SAMPLE_W(SAMPLE_W)) i_svm_checker (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .in_valid  (in_valid),
  .in_left   (in_left),
  .in_right  (in_right),
  .out_valid (out_valid),
  .out_left  (out_left),
  .out_right (out_right),
  .zero_left (zero_left),
  .zero_right(zero_right)
);

// File: tb/test_stereo_vol_meter.sv
`timescale 1ns/1ps
module test_stereo_vol_meter;

  localparam int NV = 8;
  localparam int V_VL [NV] = '{0, 1, 16, 80, 200, 7, 100, 32};
  localparam int V_VR [NV] = '{0, 2, 40, 120, 255, 13, 3, 64};
  localparam int V_XL [NV] = '{1234567, 8388607, 4000000, -3000000, 8388607, -1, 123456, -8388608};
  localparam int V_XR [NV] = '{-7654321, -8388608, -4000000, 2500000, -8388608, 1, -654321, 8388607};

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic signed [23:0] in_left, in_right;
  logic out_valid;
  logic signed [23:0] out_left, out_right;
  logic [1:0] reg_addr;
  logic reg_wr;
  logic [7:0] reg_wdata;
  logic reg_rd;
  logic [23:0] reg_rdata;
  logic zero_left, zero_right;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  stereo_vol_meter i_stereo_vol_meter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .zero_left(zero_left), .zero_right(zero_right)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic real ideal(input int k, input int x);
    return real'(x) * (10.0 ** (-0.375 * real'(k) / 20.0));
  endfunction

  task automatic check_scaled(input string req, input int k, input int x, input int y);
    real e, d, tol;
    e = ideal(k, x);
    d = real'(y) - e;
    if (d < 0.0) d = -d;
    tol = 1.0 + (x < 0 ? -real'(x) : real'(x)) * 16.0 / 8388608.0;
    check(d <= tol, req, y, longint'($rtoi(e)));
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output int v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    v = int'(reg_rdata);
  endtask

  task automatic push(input int l, input int r);
    @(negedge clk);
    in_left = 24'(l); in_right = 24'(r); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int v;
    rst_n = 1'b0; in_valid = 1'b0; in_left = '0; in_right = '0;
    reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0; reg_rd = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check(out_valid == 1'b0 && out_left == 0 && out_right == 0, "R1 reset outputs", out_left, 0);
    check(zero_left == 1'b0 && zero_right == 1'b0, "R1 reset flags", zero_left, 0);

    // R1: muted before any setting write
    push(12345, -54321);
    check(out_left == 0, "R1 left muted", out_left, 0);
    check(out_right == 0, "R1 right muted", out_right, 0);
    reg_read(2'd2, v);
    check(v == 0, "R1 left peak stays zero while muted", v, 0);

    // R1/R4: writing left unmutes only left
    reg_write(2'd0, 8'd0);
    push(12345, -54321);
    check(out_left == 12345, "R1 left unmuted by write", out_left, 12345);
    check(out_right == 0, "R4 right still muted", out_right, 0);

    // R10: setting read-back
    reg_write(2'd1, 8'h5A);
    reg_read(2'd1, v);
    check(v == 'h5A, "R10 right setting read-back", v, 'h5A);
    reg_read(2'd0, v);
    check(v == 0, "R10 left setting read-back", v, 0);

    // R3/R4: vector table, different setting per channel
    for (int i = 0; i < NV; i++) begin
      reg_write(2'd0, 8'(V_VL[i]));
      reg_write(2'd1, 8'(V_VR[i]));
      push(V_XL[i], V_XR[i]);
      check_scaled("R3 left scaled", V_VL[i], V_XL[i], int'(out_left));
      check_scaled("R3 right scaled", V_VR[i], V_XR[i], int'(out_right));
    end

    // R3: exact pass-through at setting 0
    reg_write(2'd0, 8'd0);
    reg_write(2'd1, 8'd0);
    push(-8388608, 8388607);
    check(out_left == -24'sd8388608, "R3 exact most negative", out_left, -8388608);
    check(out_right == 24'sd8388607, "R3 exact full scale", out_right, 8388607);

    // R2: strobe timing and hold
    @(negedge clk);
    in_valid = 1'b1; in_left = 24'd77; in_right = 24'd88;
    @(negedge clk);
    in_valid = 1'b0; in_left = 24'd99; in_right = 24'd99;
    check(out_valid == 1'b1 && out_left == 77, "R2 output one cycle after strobe", out_left, 77);
    @(negedge clk);
    check(out_valid == 1'b0, "R2 strobe drops", out_valid, 0);
    check(out_left == 77 && out_right == 88, "R2 output held when idle", out_left, 77);

    // R5: new setting used by the very next sample
    reg_write(2'd0, 8'd16);
    push(4000000, 4000000);
    check_scaled("R5 setting applies to next sample", 16, 4000000, int'(out_left));
    check(out_right == 4000000, "R4 right unaffected by left write", out_right, 4000000);

    // R6/R7: peak tracking and clear on read
    reg_write(2'd0, 8'd0);
    reg_read(2'd2, v);
    reg_read(2'd3, v);
    push(100, -8388608);
    push(-5000, 10);
    push(300, 20);
    reg_read(2'd2, v);
    check(v == 5000, "R6 left peak by magnitude", v, 5000);
    reg_read(2'd2, v);
    check(v == 0, "R7 peak cleared by read", v, 0);

    // R8: read and sample in the same cycle
    @(negedge clk);
    reg_addr = 2'd3; reg_rd = 1'b1; in_valid = 1'b1; in_left = 24'd1; in_right = 24'd42;
    @(negedge clk);
    reg_rd = 1'b0; in_valid = 1'b0;
    check(reg_rdata == 24'd8388607, "R6 most negative counts as full scale; R8 old value", reg_rdata, 8388607);
    reg_read(2'd3, v);
    check(v == 42, "R8 meter reloaded with coincident sample", v, 42);

    // R9: zero-run flag threshold
    @(negedge clk);
    in_valid = 1'b1; in_left = '0; in_right = 24'd7;
    repeat (1023) @(negedge clk);
    in_valid = 1'b0;
    check(zero_left == 1'b0, "R9 low after 1023 zeros", zero_left, 0);
    push(0, 7);
    check(zero_left == 1'b1, "R9 high after 1024 zeros", zero_left, 1);
    check(zero_right == 1'b0, "R9 right independent", zero_right, 0);
    push(5, 7);
    check(zero_left == 1'b0, "R9 clears on non-zero", zero_left, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule